// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a shift register of the most recent resolved branch outcomes, the global history, and combines it with the low bits of the branch address. The result selects one entry in a table of 2-bit saturating counters. The upper bit of the selected counter is the guess. A lookup is purely combinational: the address presented on the lookup port produces a direction and the table index in the same cycle.

When a branch resolves, the surrounding pipeline returns the index it was given at lookup time together with the real outcome. The block moves that counter one step toward the outcome, saturating at both ends, and shifts the outcome into the history. A parameter chooses how the address and the history are merged into an index. Concatenation places the history bits above the address bits. XOR folds a history as wide as the index onto the address bits. The address bits used always begin above the two byte-offset bits. With the defaults the table has 4K entries. Setting the index width to 14 gives a 16K-entry table.

Top module: `gbp_global_predictor`

## Requirements
- R1: After reset every counter holds 1 (weakly not taken) and the history is all zeros, so every lookup predicts not taken.
- R2: The lookup output is taken exactly when the selected counter is 2 or 3.
- R3: A taken update raises the addressed counter by one, and a counter at 3 stays at 3.
- R4: A not-taken update lowers the addressed counter by one, and a counter at 0 stays at 0.
- R5: In concatenation mode (USE_XOR=0) the index is {history[HIST_W-1:0], pc[PC_LSB+IDX_W-HIST_W-1:PC_LSB]}, with PC_LSB=2.
- R6: In XOR mode (USE_XOR=1) the history is IDX_W bits wide and the index is pc[PC_LSB+IDX_W-1:PC_LSB] XOR history.
- R7: Each accepted update shifts the history left by one, with the outcome (1 = taken) entering bit 0. In a cycle without an update the history keeps its value.
- R8: An update trains only the counter named by upd_idx, whatever the current history or lookup address. All other counters keep their values.
- R9: A lookup responds in the same cycle as its address. An update becomes visible to lookups from the next clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_pc | input | PC_W | Branch address to look up |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_idx | output | IDX_W | Table index used for this lookup |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_idx | input | IDX_W | Index that was returned at lookup time |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
A vector walk on the concatenation-mode instance runs a loop-like branch that is taken repeatedly and then exits. It also runs a pair of branches with alternating outcomes, and two addresses that differ only above the index bits. These separate a correct history placement from a swapped or misaligned one, and show that history-driven indexing gives aliasing addresses separate counters. On the XOR-mode instance, any counter can be looked up by choosing the address as the wanted index XOR the known history. That is used to drive one entry to both saturation limits and back, which tells a saturating counter apart from a wrapping one and from one that ignores the hysteresis step. Further directed steps cover history contents after a known outcome sequence, an idle cycle, a neighbouring entry that must stay untouched, and a reset in the middle of a run.

// File: rtl/gbp_pkg.sv
package gbp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'd1;
  localparam ctr_t CTR_MAX  = 2'd3;
  localparam ctr_t CTR_MIN  = 2'd0;

  // Saturating step toward the resolved outcome.
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
    else       nxt = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
    return nxt;
  endfunction

  function automatic logic ctr_says_taken(input ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/gbp_index.sv
module gbp_index #(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 12,
  parameter int HIST_W  = 4,
  parameter bit USE_XOR = 1'b0,
  parameter int PC_LSB  = 2,
  parameter int GHR_W   = USE_XOR ? IDX_W : HIST_W
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [GHR_W-1:0] ghr,
  output logic [IDX_W-1:0] idx
);

  generate
    if (USE_XOR) begin : g_xor
      logic pc_unused_bits;
      assign pc_unused_bits = ^{pc[PC_W-1:PC_LSB+IDX_W], pc[PC_LSB-1:0]};
      assign idx = pc[PC_LSB +: IDX_W] ^ ghr;
    end else begin : g_cat
      localparam int PCB_W = IDX_W - HIST_W;
      logic pc_unused_bits;
      assign pc_unused_bits = ^{pc[PC_W-1:PC_LSB+PCB_W], pc[PC_LSB-1:0]};
      assign idx = {ghr, pc[PC_LSB +: PCB_W]};
    end
  endgenerate

endmodule

// File: rtl/gbp_history.sv
module gbp_history #(
  parameter int GHR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             outcome,
  output logic [GHR_W-1:0] ghr
);

  always_ff @(posedge clk) begin
    if (rst)           ghr <= '0;
    else if (shift_en) ghr <= {ghr[GHR_W-2:0], outcome};
  end

  // R7
  ghr_shift_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (ghr[0] == $past(outcome)) && (ghr[GHR_W-1:1] == $past(ghr[GHR_W-2:0])));

  // R7
  ghr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(ghr));

endmodule

// File: rtl/gbp_table.sv
module gbp_table
  import gbp_pkg::*;
#(
  parameter int IDX_W = 12,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  ctr_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_INIT;
    end else if (wr_en) begin
      mem[wr_idx] <= ctr_step(mem[wr_idx], wr_taken);
    end
  end

  assign rd_ctr = mem[rd_idx];

  // R3
  ctr_sat_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken && mem[wr_idx] == CTR_MAX) |=> mem[$past(wr_idx)] == CTR_MAX);

  // R4
  ctr_sat_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken && mem[wr_idx] == CTR_MIN) |=> mem[$past(wr_idx)] == CTR_MIN);

  // R3
  ctr_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken && mem[wr_idx] != CTR_MAX) |=>
      mem[$past(wr_idx)] == $past(mem[wr_idx]) + 2'd1);

  // R4
  ctr_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken && mem[wr_idx] != CTR_MIN) |=>
      mem[$past(wr_idx)] == $past(mem[wr_idx]) - 2'd1);

endmodule

// File: rtl/gbp_global_predictor.sv
module gbp_global_predictor
  import gbp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 12,
  parameter int HIST_W  = 4,
  parameter bit USE_XOR = 1'b0,
  parameter int PC_LSB  = 2,
  localparam int GHR_W  = USE_XOR ? IDX_W : HIST_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PC_W-1:0]  pred_pc,
  output logic             pred_taken,
  output logic [IDX_W-1:0] pred_idx,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken
);

  logic [GHR_W-1:0] ghr;
  ctr_t             sel_ctr;

  gbp_history #(.GHR_W(GHR_W)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .shift_en (upd_valid),
    .outcome  (upd_taken),
    .ghr      (ghr)
  );

  gbp_index #(
    .PC_W    (PC_W),
    .IDX_W   (IDX_W),
    .HIST_W  (HIST_W),
    .USE_XOR (USE_XOR),
    .PC_LSB  (PC_LSB),
    .GHR_W   (GHR_W)
  ) u_idx (
    .pc  (pred_pc),
    .ghr (ghr),
    .idx (pred_idx)
  );

  gbp_table #(.IDX_W(IDX_W)) u_tbl (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (pred_idx),
    .rd_ctr   (sel_ctr),
    .wr_en    (upd_valid),
    .wr_idx   (upd_idx),
    .wr_taken (upd_taken)
  );

  assign pred_taken = ctr_says_taken(sel_ctr);

  // R9
  pred_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (!upd_valid && $stable(pred_pc)) |=> $stable(pred_taken) && $stable(pred_idx));

endmodule

// File: tb/gbp_global_predictor_tb.sv
module gbp_global_predictor_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;

  // concatenation-mode instance (defaults: 12-bit index, 4 history bits)
  logic [31:0] c_pred_pc = '0;
  logic        c_pred_taken;
  logic [11:0] c_pred_idx;
  logic        c_upd_valid = 1'b0;
  logic [11:0] c_upd_idx = '0;
  logic        c_upd_taken = 1'b0;

  gbp_global_predictor u_dut (
    .clk(clk), .rst(rst),
    .pred_pc(c_pred_pc), .pred_taken(c_pred_taken), .pred_idx(c_pred_idx),
    .upd_valid(c_upd_valid), .upd_idx(c_upd_idx), .upd_taken(c_upd_taken)
  );

  // XOR-mode instance with a 6-bit index
  logic [31:0] x_pred_pc = '0;
  logic        x_pred_taken;
  logic [5:0]  x_pred_idx;
  logic        x_upd_valid = 1'b0;
  logic [5:0]  x_upd_idx = '0;
  logic        x_upd_taken = 1'b0;

  gbp_global_predictor #(.IDX_W(6), .HIST_W(6), .USE_XOR(1'b1)) u_dut_xor (
    .clk(clk), .rst(rst),
    .pred_pc(x_pred_pc), .pred_taken(x_pred_taken), .pred_idx(x_pred_idx),
    .upd_valid(x_upd_valid), .upd_idx(x_upd_idx), .upd_taken(x_upd_taken)
  );

  // reference state built from the requirements
  logic [1:0] mc [4096];
  logic [1:0] mx [64];
  logic [3:0] mgc;
  logic [5:0] mgx;

  function automatic logic [1:0] sat(input logic [1:0] c, input logic tk);
    if (tk) return (c == 2'd3) ? 2'd3 : c + 2'd1;
    return (c == 2'd0) ? 2'd0 : c - 2'd1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_init();
    for (int i = 0; i < 4096; i++) mc[i] = 2'd1;
    for (int i = 0; i < 64; i++) mx[i] = 2'd1;
    mgc = '0;
    mgx = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    rst = 1'b0;
    model_init();
  endtask

  task automatic c_step(input logic [31:0] pc, input logic tk);
    logic [11:0] ei;
    ei = {mgc, pc[9:2]};
    c_pred_pc = pc; #1;
    chk("R5 concat index", 32'(c_pred_idx), 32'(ei));
    chk("R2 direction", 32'(c_pred_taken), 32'(mc[ei] >= 2'd2));
    c_upd_valid = 1'b1; c_upd_idx = ei; c_upd_taken = tk;
    @(posedge clk); #1;
    c_upd_valid = 1'b0;
    mc[ei] = sat(mc[ei], tk);
    mgc = {mgc[2:0], tk};
  endtask

  task automatic x_upd(input logic [5:0] k, input logic tk);
    x_upd_valid = 1'b1; x_upd_idx = k; x_upd_taken = tk;
    @(posedge clk); #1;
    x_upd_valid = 1'b0;
    mx[k] = sat(mx[k], tk);
    mgx = {mgx[4:0], tk};
  endtask

  task automatic x_look(input string req, input logic [5:0] k);
    x_pred_pc = 32'(k ^ mgx) << 2; #1;
    chk({req, " xor index (R6)"}, 32'(x_pred_idx), 32'(k));
    chk(req, 32'(x_pred_taken), 32'(mx[k] >= 2'd2));
  endtask

  typedef struct packed {
    logic [31:0] pc;
    logic        tk;
  } vec_t;

  localparam vec_t VEC [20] = '{
    '{32'h0000_0100, 1'b1}, '{32'h0000_0100, 1'b1}, '{32'h0000_0100, 1'b1},
    '{32'h0000_0100, 1'b1}, '{32'h0000_0100, 1'b1}, '{32'h0000_0100, 1'b1},
    '{32'h0000_0100, 1'b0}, '{32'h0000_0200, 1'b1}, '{32'h0000_0204, 1'b0},
    '{32'h0000_0200, 1'b1}, '{32'h0000_0204, 1'b0}, '{32'h0000_0200, 1'b1},
    '{32'h0000_0204, 1'b0}, '{32'h0000_1100, 1'b1}, '{32'h0000_0100, 1'b0},
    '{32'h0000_1100, 1'b1}, '{32'h0000_03FC, 1'b1}, '{32'h0000_03FF, 1'b0},
    '{32'h0000_0100, 1'b1}, '{32'h0000_0100, 1'b1}
  };

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();

    // R1: reset state, history zero so the index is just the address bits
    c_pred_pc = 32'h0000_0ABC; #1;
    chk("R1 reset predicts not taken", 32'(c_pred_taken), 32'd0);
    chk("R1 reset history zero", 32'(c_pred_idx), 32'h0AF);
    x_pred_pc = 32'h0000_00FC; #1;
    chk("R1 reset xor not taken", 32'(x_pred_taken), 32'd0);
    chk("R1 reset xor history zero", 32'(x_pred_idx), 32'h3F);

    // R2 R5 R8 R9: vector walk on the concatenation instance
    for (int i = 0; i < 20; i++) c_step(VEC[i].pc, VEC[i].tk);

    // R9: lookup answers within the cycle, no clock edge needed
    c_pred_pc = 32'h0000_0010; #1;
    chk("R9 same-cycle index", 32'(c_pred_idx), 32'({mgc, 8'h04}));
    c_pred_pc = 32'h0000_0014; #1;
    chk("R9 same-cycle index change", 32'(c_pred_idx), 32'({mgc, 8'h05}));

    do_reset();

    // R7: history contents after taken, taken, not taken; hold on idle cycle
    x_upd(6'h00, 1'b1); x_upd(6'h00, 1'b1); x_upd(6'h00, 1'b0);
    x_pred_pc = 32'h0; #1;
    chk("R7 history after T,T,N", 32'(x_pred_idx), 32'h06);
    @(posedge clk); #1;
    chk("R7 history held when idle", 32'(x_pred_idx), 32'h06);

    // R3: saturate at 3
    x_upd(6'h15, 1'b1);
    x_look("R3 weak taken", 6'h15);
    x_upd(6'h15, 1'b1); x_upd(6'h15, 1'b1); x_upd(6'h15, 1'b1);
    x_look("R3 saturated high", 6'h15);
    x_upd(6'h15, 1'b0);
    x_look("R3 one step down still taken", 6'h15);
    // R4: saturate at 0 then climb back
    x_upd(6'h15, 1'b0); x_upd(6'h15, 1'b0); x_upd(6'h15, 1'b0); x_upd(6'h15, 1'b0);
    x_look("R4 saturated low", 6'h15);
    x_upd(6'h15, 1'b1);
    x_look("R4 one step up still not taken", 6'h15);
    x_upd(6'h15, 1'b1);
    x_look("R4 two steps up taken", 6'h15);
    // R8: neighbour untouched while the history moved around it
    x_look("R8 neighbour untouched", 6'h14);
    x_look("R8 other entry untouched", 6'h2A);
    chk("R8 counter 0x15 value", 32'(mx[6'h15]), 32'd2);

    // R1: reset in the middle of a run clears trained state
    do_reset();
    x_look("R1 mid-run reset", 6'h15);
    x_pred_pc = 32'h0; #1;
    chk("R1 mid-run reset history", 32'(x_pred_idx), 32'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule